// File: doc/BRIEF.md
# Buffered Flash Page-Program Sequencer

This block sends one page-program transaction to a serial NOR flash. Software fills a small set of write-only registers through a single write port: the instruction byte, up to four address bytes, an address-width select, a mode select, and either one data byte or a stream of 32-bit data words. It then sets a start bit. The block drives chip select, serial clock and serial data out until the last data bit has left, and holds a busy flag for the whole transfer.

There are two data modes. In page mode, words written to the data-word register are unpacked into a 128-byte page buffer, and the transfer carries all 128 bytes. In single-byte mode, the transfer carries one byte taken from the single-byte register. The serial clock runs at half the system clock, in mode 0: the clock idles low, data changes while the clock is low, and the flash samples on the rising edge. Write-enable generation and status polling are not part of this block.

Register selects on `wr_sel`:

| Select | Register | Fields used |
|---|---|---|
| 0 | command | bit 4 = start |
| 1 | mode | bit 0 = page mode |
| 2 | bus | bit 4 = 4-byte address |
| 3 | instruction | bits 7:0 |
| 4 to 7 | address bytes 0 (least significant) to 3 | bits 7:0 |
| 8 | single data byte | bits 7:0 |
| 9 | page data word | bits 31:0 |

Top module: `flash_page_prog`

## Requirements
- R1: After reset, `busy` is 0, `spi_cs_n` is 1, `spi_sck` is 0, `page_mode` is 0, and the page write pointer is 0.
- R2: A transaction sends the instruction byte (select 3) first, then the address bytes starting with the most significant one, then the data bytes. Each byte goes out most significant bit first. `spi_mosi` changes only while `spi_sck` is low, and is valid at each rising edge of `spi_sck`.
- R3: When bus register (select 2) bit 4 is 1, four address bytes are sent (select 7 down to select 4). When it is 0, three address bytes are sent (select 6 down to select 4).
- R4: With `page_mode` = 0, exactly one data byte is sent: bits 7:0 of the single data byte register (select 8).
- R5: With `page_mode` = 1, exactly 128 data bytes are sent. Each page data word (select 9) contributes four bytes in this order: bits 7:0, then 15:8, then 23:16, then 31:24. Words are used in the order they were written.
- R6: Writing mode register (select 1) bit 0 sets `page_mode`, and the new value can be read back on the cycle after the write.
- R7: A write to the command register (select 0) with bit 4 set starts a transfer. `busy` and chip select go active on the next cycle. The transfer lasts exactly 16 clock cycles per byte. Then `busy` clears and `spi_cs_n` returns high.
- R8: Page data words written after 32 words have already been stored are ignored.
- R9: When a page-mode transfer completes, the page write pointer returns to 0, so the next word written becomes bytes 0 to 3 of the next page.
- R10: All register writes, including start, mode changes and data words, are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| page_mode | output | 1 | Mode register read-back (1 = page mode) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The hardest case to reach from the ports is the page buffer when more than 32 words are written. The overflow words must be dropped, and the buffer must then start again at word 0 after the page has been sent. The bench writes 34 words, with the two surplus words carrying a marker pattern. It checks that all 128 captured data bytes come from the first 32 words. It then reloads a fresh page with a different seed and sends it with a 4-byte address. The bench also issues register writes in the middle of a transfer and checks that they leave the next frame and the mode read-back unchanged.

// File: rtl/fpp_pkg.sv
// Shared register selects and field positions for the page-program sequencer.
package fpp_pkg;
    localparam logic [3:0] SEL_CMD   = 4'd0;
    localparam logic [3:0] SEL_MODE  = 4'd1;
    localparam logic [3:0] SEL_BUS   = 4'd2;
    localparam logic [3:0] SEL_INSN  = 4'd3;
    localparam logic [3:0] SEL_ADR0  = 4'd4;
    localparam logic [3:0] SEL_ADR1  = 4'd5;
    localparam logic [3:0] SEL_ADR2  = 4'd6;
    localparam logic [3:0] SEL_ADR3  = 4'd7;
    localparam logic [3:0] SEL_BYTE  = 4'd8;
    localparam logic [3:0] SEL_WORD  = 4'd9;
    localparam int START_BIT = 4;
    localparam int PAGE_BIT  = 0;
    localparam int ADR4_BIT  = 4;
endpackage

// File: rtl/fpp_page_buf.sv
// Page buffer: stores little-endian packed words and serves single bytes by index.
// Assumes: the write pointer saturates at WORDS, so extra words are dropped.
// Assumes: clr has priority over we.
module fpp_page_buf #(
    parameter int PAGE_BYTES = 128,
    localparam int WORDS = PAGE_BYTES / 4,
    localparam int PW    = $clog2(WORDS + 1),
    localparam int BW    = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [31:0]   wdata,
    input  logic          clr,
    input  logic [BW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [PW-1:0] wptr
);
    logic [31:0] mem [WORDS];
    logic [31:0] rd_word;

    // Advance the write pointer on accepted words; clear it when a page has been sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (clr) begin
            wptr <= '0;
        end else if (we && (wptr < PW'(WORDS))) begin
            wptr <= wptr + PW'(1);
        end
    end

    // Store the accepted word at the current pointer.
    always_ff @(posedge clk) begin
        if (we && !clr && (wptr < PW'(WORDS))) begin
            mem[wptr[PW-2:0]] <= wdata;
        end
    end

    // Byte select: lowest index bits pick the lane, least significant lane first.
    always_comb begin
        rd_word = mem[rd_idx[BW-1:2]];
        rd_byte = rd_word[rd_idx[1:0]*8 +: 8];
    end

    assert_ptr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wptr <= PW'(WORDS));
    assert_ptr_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr == PW'(WORDS) && !clr) |=> (wptr == PW'(WORDS)));
endmodule

// File: rtl/fpp_shifter.sv
// Frame shifter: walks byte index and bit position and drives mode-0 serial pins.
// Assumes: byte_in depends only on idx and on registers that are stable while busy.
// Assumes: the serial clock is half the system clock.
module fpp_shifter #(
    parameter int IDXW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IDXW-1:0] total,
    input  logic [7:0]      byte_in,
    output logic [IDXW-1:0] idx,
    output logic            busy,
    output logic            done,
    output logic            sck,
    output logic            mosi,
    output logic            cs_n
);
    logic            phase_q;
    logic [2:0]      bit_q;
    logic [IDXW-1:0] total_q;

    // Sequence low/high clock phases, bits, then bytes until the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            phase_q <= 1'b0;
            bit_q   <= 3'd7;
            idx     <= '0;
            total_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                phase_q <= 1'b0;
                bit_q   <= 3'd7;
                idx     <= '0;
                total_q <= total;
            end
        end else if (!phase_q) begin
            phase_q <= 1'b1;
        end else begin
            phase_q <= 1'b0;
            bit_q   <= bit_q - 3'd1;
            if (bit_q == 3'd0) begin
                if (done) busy <= 1'b0;
                else      idx  <= idx + IDXW'(1);
            end
        end
    end

    // Pin and completion decode from the sequencing state.
    always_comb begin
        done = busy && phase_q && (bit_q == 3'd0) && (idx == total_q - IDXW'(1));
        sck  = busy && phase_q;
        mosi = busy && byte_in[bit_q];
        cs_n = !busy;
    end

    assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));
    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx < total_q));
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !sck));
endmodule

// File: rtl/flash_page_prog.sv
// Page-program sequencer top: register write port, frame byte selection, buffer and shifter.
// Assumes: software waits for busy to clear before writing; writes during busy are dropped.
module flash_page_prog #(
    parameter int PAGE_BYTES = 128,
    localparam int IDXW = $clog2(PAGE_BYTES + 6),
    localparam int BW   = $clog2(PAGE_BYTES),
    localparam int PW   = $clog2(PAGE_BYTES / 4 + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        busy,
    output logic        page_mode,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi
);
    import fpp_pkg::*;

    logic [7:0]      insn_q;
    logic [3:0][7:0] adr_q;
    logic [7:0]      byte_q;
    logic            adr4_q;
    logic            wr_ok;
    logic            start;
    logic            done;
    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] alen;
    logic [IDXW-1:0] total;
    logic [1:0]      asel;
    logic [BW-1:0]   rd_idx;
    logic [7:0]      buf_byte;
    logic [7:0]      cur_byte;
    logic [PW-1:0]   wptr;

    // Register write decode, gated off while a transfer runs.
    always_comb begin
        wr_ok = wr_en && !busy;
        start = wr_ok && (wr_sel == SEL_CMD) && wr_data[START_BIT];
    end

    // Configuration and frame-content registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_q    <= '0;
            adr_q     <= '0;
            byte_q    <= '0;
            adr4_q    <= 1'b0;
            page_mode <= 1'b0;
        end else if (wr_ok) begin
            case (wr_sel)
                SEL_MODE: page_mode <= wr_data[PAGE_BIT];
                SEL_BUS:  adr4_q    <= wr_data[ADR4_BIT];
                SEL_INSN: insn_q    <= wr_data[7:0];
                SEL_ADR0: adr_q[0]  <= wr_data[7:0];
                SEL_ADR1: adr_q[1]  <= wr_data[7:0];
                SEL_ADR2: adr_q[2]  <= wr_data[7:0];
                SEL_ADR3: adr_q[3]  <= wr_data[7:0];
                SEL_BYTE: byte_q    <= wr_data[7:0];
                default: ;
            endcase
        end
    end

    // Frame length and the byte that belongs at the current frame index.
    always_comb begin
        alen   = adr4_q ? IDXW'(4) : IDXW'(3);
        total  = IDXW'(1) + alen + (page_mode ? IDXW'(PAGE_BYTES) : IDXW'(1));
        asel   = alen[1:0] - idx[1:0];
        rd_idx = idx[BW-1:0] - alen[BW-1:0] - BW'(1);
        if (idx == '0)        cur_byte = insn_q;
        else if (idx <= alen) cur_byte = adr_q[asel];
        else if (page_mode)   cur_byte = buf_byte;
        else                  cur_byte = byte_q;
    end

    fpp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_ok && (wr_sel == SEL_WORD)),
        .wdata   (wr_data),
        .clr     (done && page_mode),
        .rd_idx  (rd_idx),
        .rd_byte (buf_byte),
        .wptr    (wptr)
    );

    fpp_shifter #(.IDXW(IDXW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .total   (total),
        .byte_in (cur_byte),
        .idx     (idx),
        .busy    (busy),
        .done    (done),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n)
    );

    assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && page_mode) |=> (wptr == '0));
    assert_frozen_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(insn_q) && $stable(page_mode) && $stable(adr4_q)));
    assert_cs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> (busy && !spi_cs_n));
endmodule

// File: tb/flash_page_prog_tb.sv
module flash_page_prog_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        busy, page_mode, spi_cs_n, spi_sck, spi_mosi;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] cap [0:139];
    int         cap_n = 0;
    int         bit_n = 0;
    logic [7:0] sh = '0;
    int         busy_cyc = 0;
    logic       prev_sck = 1'b0;
    logic [7:0] expb [0:139];
    int         exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_page_prog u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .page_mode(page_mode), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    // Serial monitor: capture bits at rising serial clock, count busy cycles.
    always @(negedge clk) begin
        if (!spi_cs_n && spi_sck && !prev_sck) begin
            sh = {sh[6:0], spi_mosi};
            bit_n++;
            if (bit_n == 8) begin
                if (cap_n < 140) cap[cap_n] = sh;
                cap_n++;
                bit_n = 0;
            end
        end
        if (busy) busy_cyc++;
        prev_sck = spi_sck;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 7 + k * 13 + (k >> 3)) & 255);
    endfunction

    task automatic setup_regs(input logic [7:0] op, input logic [31:0] a, input bit a4,
                              input logic [7:0] wb);
        wr(4'd3, {24'h0, op});
        wr(4'd4, {24'h0, a[7:0]});
        wr(4'd5, {24'h0, a[15:8]});
        wr(4'd6, {24'h0, a[23:16]});
        wr(4'd7, {24'h0, a[31:24]});
        wr(4'd2, {27'h0, a4, 4'h0});
        wr(4'd8, {24'hFFFFFF, wb});
    endtask

    task automatic build(input logic [7:0] op, input logic [31:0] a, input bit a4,
                         input bit pg, input logic [7:0] wb, input int seed);
        exp_n = 0;
        expb[exp_n++] = op;
        for (int k = (a4 ? 3 : 2); k >= 0; k--) expb[exp_n++] = a[8*k +: 8];
        if (pg) for (int k = 0; k < 128; k++) expb[exp_n++] = pat(seed, k);
        else    expb[exp_n++] = wb;
    endtask

    task automatic load_page(input int seed, input int extra);
        for (int j = 0; j < 32; j++)
            wr(4'd9, {pat(seed, 4*j+3), pat(seed, 4*j+2), pat(seed, 4*j+1), pat(seed, 4*j)});
        for (int j = 0; j < extra; j++) wr(4'd9, 32'hDEAD_BE00 | 32'(j));
    endtask

    task automatic start_xfer;
        cap_n = 0; bit_n = 0; busy_cyc = 0;
        wr(4'd0, 32'h10);
        chk(busy && !spi_cs_n, "R7 busy/cs after start", {busy, spi_cs_n}, 2'b10);
    endtask

    task automatic finish_xfer(input string tag);
        int bad;
        int first;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(cap_n == exp_n, {tag, " byte count"}, cap_n, exp_n);
        chk(busy_cyc == 16 * exp_n, "R7 busy cycles", busy_cyc, 16 * exp_n);
        chk(spi_cs_n && !spi_sck, "R7 idle pins after transfer", {spi_cs_n, spi_sck}, 2'b10);
        bad = 0; first = 0;
        for (int k = 0; k < exp_n && k < cap_n; k++)
            if (cap[k] !== expb[k]) begin
                if (bad == 0) first = k;
                bad++;
            end
        chk(bad == 0, {tag, " R2 frame bytes"}, bad == 0 ? 0 : cap[first], bad == 0 ? 0 : expb[first]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy", busy, 0);
        chk(spi_cs_n && !spi_sck, "R1 pins", {spi_cs_n, spi_sck}, 2'b10);
        chk(!page_mode, "R1 page_mode", page_mode, 0);

        // R3/R4 single-byte sweep over address widths and values
        for (int a4 = 0; a4 < 2; a4++)
            for (int v = 0; v < 4; v++) begin
                logic [31:0] a;
                logic [7:0] op, wb;
                a  = 32'h8142_C3A5 ^ (32'h1357_9BDF * 32'(v + 1));
                op = 8'h02 + 8'(v * 16 + a4);
                wb = 8'h5A ^ 8'(v * 37);
                setup_regs(op, a, a4[0], wb);
                build(op, a, a4[0], 1'b0, wb, 0);
                start_xfer();
                finish_xfer(a4 ? "R3 R4 4-byte" : "R3 R4 3-byte");
            end

        // R10 writes during busy are ignored
        setup_regs(8'h12, 32'h0A0B_0C0D, 1'b0, 8'h77);
        build(8'h12, 32'h0A0B_0C0D, 1'b0, 1'b0, 8'h77, 0);
        start_xfer();
        wr(4'd3, 32'hEE);
        wr(4'd1, 32'h1);
        wr(4'd0, 32'h10);
        chk(!page_mode, "R10 mode write ignored while busy", page_mode, 0);
        finish_xfer("R10 first");
        start_xfer();
        finish_xfer("R10 opcode kept");

        // R6 mode read-back
        wr(4'd1, 32'h1);
        chk(page_mode, "R6 page_mode readback", page_mode, 1);

        // R5 R8 page with two surplus words
        setup_regs(8'h32, 32'h0012_3450, 1'b0, 8'h00);
        load_page(3, 2);
        build(8'h32, 32'h0012_3450, 1'b0, 1'b1, 8'h00, 3);
        start_xfer();
        finish_xfer("R5 R8 page overflow");

        // R9 pointer restarts: fresh page with 4-byte address
        setup_regs(8'h3E, 32'hF1E2_D3C4, 1'b1, 8'h00);
        load_page(11, 0);
        build(8'h3E, 32'hF1E2_D3C4, 1'b1, 1'b1, 8'h00, 11);
        start_xfer();
        finish_xfer("R9 R5 second page");

        // R6 back to single-byte mode
        wr(4'd1, 32'h0);
        chk(!page_mode, "R6 page_mode cleared", page_mode, 0);
        setup_regs(8'h02, 32'h0000_0100, 1'b0, 8'hC3);
        build(8'h02, 32'h0000_0100, 1'b0, 1'b0, 8'hC3, 0);
        start_xfer();
        finish_xfer("R4 after page mode");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule